// File: doc/BRIEF.md
# Epoch-Tagged Persistent Store Queue

This block sits beside a core's first-level cache and keeps, in program order, every store the thread makes to persistent memory. Each entry holds the line address, the stored value, and the epoch number that was open when the store was made. A store counts as persistent when the top bits of its address match a configured region selector. Other stores pass by without leaving an entry.

The epoch number lives in a local register. Both kinds of fence advance it: the ordering fence and the durability fence. Drain logic downstream reads the oldest entry through a head port and pops it. That logic can drain all entries of one epoch in parallel, and it must keep different epochs apart. Two stores to the same address stay as two separate entries, so older values still reach memory in their proper epoch. Lookups are never made inside the queue.

When this thread loses exclusive ownership of a line, the coherence side reports the other thread's identifier and that thread's epoch. The block holds this dependency and stamps it onto the next entry it inserts. Drain logic can then wait until the other thread has made that epoch durable.

Top module: `pbuf_front`

## Requirements
- R1: After reset the queue is empty (`empty`=1, `full`=0, `hd_valid`=0) and `local_ts` equals 0.
- R2: A store is persistent only when `st_addr[ADDR_W-1 -: PM_SEL_W]` equals `PM_SEL_VAL`. Any other store creates no entry and never raises `st_stall`.
- R3: `local_ts` rises by one for each fence input that is high in a cycle. If `ord_fence` and `dur_fence` are both high, it rises by two. A store in the same cycle as a fence takes the value from before the fence.
- R4: Each accepted persistent store appends one entry with its address, its data and the current `local_ts`. Entries leave at the head in the same order they arrived.
- R5: Two stores to the same address produce two distinct entries, each keeping its own data and epoch. Nothing is merged.
- R6: A held dependency (thread id, epoch) is attached to the next accepted persistent store only. That entry shows `hd_dep_valid`=1. The entries after it show `hd_dep_valid`=0 unless a new dependency arrives.
- R7: A new dependency replaces a held one only when its thread id is the same and its epoch is strictly greater (unsigned compare). In every other case the held one is kept.
- R8: A dependency that arrives in the same cycle as an accepted store is not attached to that store. It is held for the next one.
- R9: The queue is full at `DEPTH` entries. A persistent store while full raises `st_stall` in that cycle and is not recorded. This holds even when the head is popped in the same cycle.
- R10: The head outputs always show the oldest entry. `hd_pop` removes it at the clock edge. A pop while the queue is empty has no effect.
- R11: `local_ts` wraps modulo 2^`TS_W`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Store presented this cycle |
| st_addr | input | ADDR_W | Store line address |
| st_data | input | DATA_W | Store value |
| st_stall | output | 1 | Persistent store refused because the queue is full |
| ord_fence | input | 1 | Ordering fence executed |
| dur_fence | input | 1 | Durability fence executed |
| dep_valid | input | 1 | Cross-thread dependency reported |
| dep_tid | input | TID_W | Identifier of the other thread |
| dep_ts | input | TS_W | Epoch of the other thread |
| hd_valid | output | 1 | Head entry present |
| hd_addr | output | ADDR_W | Head entry address |
| hd_data | output | DATA_W | Head entry value |
| hd_ts | output | TS_W | Head entry epoch |
| hd_dep_valid | output | 1 | Head entry carries a dependency |
| hd_dep_tid | output | TID_W | Dependency thread id |
| hd_dep_ts | output | TS_W | Dependency epoch |
| hd_pop | input | 1 | Remove the head entry |
| full | output | 1 | DEPTH entries held |
| empty | output | 1 | No entries held |
| local_ts | output | TS_W | Epoch currently open |

## Verification
The assertions check the following on every cycle:
- The epoch holds steady when no fence is seen, and moves by exactly one for a single fence.
- A full queue stalls persistent stores, and non-persistent stores never stall.
- `full` and `empty` are never high together.
- The head entry stays fixed until it is popped.

The bench's scenarios alone can show the rest. These are the exact content and order of entries, the dependency merge and hand-off rules, the same-cycle store and fence order, and the wrap of the epoch counter. The bench checks these against an arithmetic model over a small configuration, swept in a pseudo-random way.

// File: rtl/pbuf_pkg.sv
package pbuf_pkg;
    localparam int unsigned PB_DEPTH   = 64;
    localparam int unsigned PB_ADDR_W  = 32;
    localparam int unsigned PB_DATA_W  = 32;
    localparam int unsigned PB_TS_W    = 16;
    localparam int unsigned PB_TID_W   = 4;
    localparam int unsigned PB_SEL_W   = 4;
    localparam int unsigned PB_SEL_VAL = 15;

    // {pop, push} after gating
    typedef enum logic [1:0] {
        Q_IDLE = 2'b00,
        Q_PUSH = 2'b01,
        Q_POP  = 2'b10,
        Q_BOTH = 2'b11
    } q_op_e;
endpackage

// File: rtl/pbuf_epoch.sv
module pbuf_epoch #(
    parameter int unsigned TS_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            inc_a,
    input  logic            inc_b,
    output logic [TS_W-1:0] ts
);
    typedef struct packed {
        logic [TS_W-1:0] ts;
    } ep_t;

    ep_t s_d, s_q;

    always_comb begin
        s_d    = s_q;
        s_d.ts = s_q.ts + TS_W'(inc_a) + TS_W'(inc_b);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign ts = s_q.ts;
endmodule

// File: rtl/pbuf_dep_hold.sv
module pbuf_dep_hold #(
    parameter int unsigned TID_W = 4,
    parameter int unsigned TS_W  = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_v,
    input  logic [TID_W-1:0] in_tid,
    input  logic [TS_W-1:0]  in_ts,
    input  logic             take,
    output logic             held_v,
    output logic [TID_W-1:0] held_tid,
    output logic [TS_W-1:0]  held_ts
);
    typedef struct packed {
        logic             v;
        logic [TID_W-1:0] tid;
        logic [TS_W-1:0]  ts;
    } dep_t;

    dep_t s_d, s_q;
    logic newer;

    always_comb begin
        s_d   = s_q;
        newer = !s_q.v || ((in_tid == s_q.tid) && (in_ts > s_q.ts));
        if (take) begin
            // consumed this cycle: an arrival now waits for the following store
            s_d.v   = in_v;
            s_d.tid = in_tid;
            s_d.ts  = in_ts;
        end else if (in_v && newer) begin
            s_d.v   = 1'b1;
            s_d.tid = in_tid;
            s_d.ts  = in_ts;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign held_v   = s_q.v;
    assign held_tid = s_q.tid;
    assign held_ts  = s_q.ts;
endmodule

// File: rtl/pbuf_ring.sv
module pbuf_ring
    import pbuf_pkg::*;
#(
    parameter int unsigned DEPTH = 64,
    parameter int unsigned W     = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] rdata,
    output logic         full,
    output logic         empty
);
    localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [AW-1:0] rd;
        logic [AW-1:0] wr;
        logic [CW-1:0] cnt;
    } ring_t;

    ring_t  s_d, s_q;
    q_op_e  op;
    logic   push_ok, pop_ok;
    logic [W-1:0] mem [DEPTH];

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full    = (s_q.cnt == CW'(DEPTH));
    assign empty   = (s_q.cnt == '0);
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;

    always_comb begin
        s_d = s_q;
        op  = q_op_e'({pop_ok, push_ok});
        case (op)
            Q_PUSH: begin
                s_d.wr  = bump(s_q.wr);
                s_d.cnt = s_q.cnt + 1'b1;
            end
            Q_POP: begin
                s_d.rd  = bump(s_q.rd);
                s_d.cnt = s_q.cnt - 1'b1;
            end
            Q_BOTH: begin
                s_d.wr = bump(s_q.wr);
                s_d.rd = bump(s_q.rd);
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem[s_q.wr] <= wdata;
    end

    assign rdata = mem[s_q.rd];
endmodule

// File: rtl/pbuf_front.sv
module pbuf_front
    import pbuf_pkg::*;
#(
    parameter int unsigned DEPTH      = PB_DEPTH,
    parameter int unsigned ADDR_W     = PB_ADDR_W,
    parameter int unsigned DATA_W     = PB_DATA_W,
    parameter int unsigned TS_W       = PB_TS_W,
    parameter int unsigned TID_W      = PB_TID_W,
    parameter int unsigned PM_SEL_W   = PB_SEL_W,
    parameter int unsigned PM_SEL_VAL = PB_SEL_VAL
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              st_valid,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic [DATA_W-1:0] st_data,
    output logic              st_stall,
    input  logic              ord_fence,
    input  logic              dur_fence,
    input  logic              dep_valid,
    input  logic [TID_W-1:0]  dep_tid,
    input  logic [TS_W-1:0]   dep_ts,
    output logic              hd_valid,
    output logic [ADDR_W-1:0] hd_addr,
    output logic [DATA_W-1:0] hd_data,
    output logic [TS_W-1:0]   hd_ts,
    output logic              hd_dep_valid,
    output logic [TID_W-1:0]  hd_dep_tid,
    output logic [TS_W-1:0]   hd_dep_ts,
    input  logic              hd_pop,
    output logic              full,
    output logic              empty,
    output logic [TS_W-1:0]   local_ts
);
    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic [TS_W-1:0]   ts;
        logic              dv;
        logic [TID_W-1:0]  dtid;
        logic [TS_W-1:0]   dts;
    } ent_t;

    localparam int unsigned ENT_W = $bits(ent_t);

    logic             is_pm, st_req, accept;
    logic             held_v;
    logic [TID_W-1:0] held_tid;
    logic [TS_W-1:0]  held_ts;
    ent_t             new_ent, head_ent;
    logic [ENT_W-1:0] head_raw;

    assign is_pm    = (st_addr[ADDR_W-1 -: PM_SEL_W] == PM_SEL_W'(PM_SEL_VAL));
    assign st_req   = st_valid && is_pm;
    assign st_stall = st_req && full;
    assign accept   = st_req && !full;

    pbuf_epoch #(.TS_W(TS_W)) u_epoch (
        .clk   (clk),
        .rst_n (rst_n),
        .inc_a (ord_fence),
        .inc_b (dur_fence),
        .ts    (local_ts)
    );

    pbuf_dep_hold #(.TID_W(TID_W), .TS_W(TS_W)) u_dep (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_v     (dep_valid),
        .in_tid   (dep_tid),
        .in_ts    (dep_ts),
        .take     (accept),
        .held_v   (held_v),
        .held_tid (held_tid),
        .held_ts  (held_ts)
    );

    always_comb begin
        new_ent.addr = st_addr;
        new_ent.data = st_data;
        new_ent.ts   = local_ts;
        new_ent.dv   = held_v;
        new_ent.dtid = held_tid;
        new_ent.dts  = held_ts;
    end

    pbuf_ring #(.DEPTH(DEPTH), .W(ENT_W)) u_ring (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (accept),
        .wdata (new_ent),
        .pop   (hd_pop),
        .rdata (head_raw),
        .full  (full),
        .empty (empty)
    );

    assign head_ent     = ent_t'(head_raw);
    assign hd_valid     = !empty;
    assign hd_addr      = head_ent.addr;
    assign hd_data      = head_ent.data;
    assign hd_ts        = head_ent.ts;
    assign hd_dep_valid = head_ent.dv;
    assign hd_dep_tid   = head_ent.dtid;
    assign hd_dep_ts    = head_ent.dts;
endmodule

// File: rtl/pbuf_front_chk.sv
module pbuf_front_chk #(
    parameter int unsigned DEPTH      = 64,
    parameter int unsigned ADDR_W     = 32,
    parameter int unsigned DATA_W     = 32,
    parameter int unsigned TS_W       = 16,
    parameter int unsigned TID_W      = 4,
    parameter int unsigned PM_SEL_W   = 4,
    parameter int unsigned PM_SEL_VAL = 15
) (
    input logic              clk,
    input logic              rst_n,
    input logic              st_valid,
    input logic [ADDR_W-1:0] st_addr,
    input logic [DATA_W-1:0] st_data,
    input logic              st_stall,
    input logic              ord_fence,
    input logic              dur_fence,
    input logic              dep_valid,
    input logic [TID_W-1:0]  dep_tid,
    input logic [TS_W-1:0]   dep_ts,
    input logic              hd_valid,
    input logic [ADDR_W-1:0] hd_addr,
    input logic [DATA_W-1:0] hd_data,
    input logic [TS_W-1:0]   hd_ts,
    input logic              hd_dep_valid,
    input logic [TID_W-1:0]  hd_dep_tid,
    input logic [TS_W-1:0]   hd_dep_ts,
    input logic              hd_pop,
    input logic              full,
    input logic              empty,
    input logic [TS_W-1:0]   local_ts
);
    logic sel_hit;
    assign sel_hit = (st_addr[ADDR_W-1 -: PM_SEL_W] == PM_SEL_W'(PM_SEL_VAL));

    p_ts_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ord_fence && !dur_fence) |=> $stable(local_ts));

    p_ts_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ord_fence ^ dur_fence) |=> (local_ts == TS_W'($past(local_ts) + 1'b1)));

    p_nonpm_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && !sel_hit) |-> !st_stall);

    p_stall_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && sel_hit && full) |-> st_stall);

    p_flags_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && empty));

    p_stay_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !hd_pop) |=> full);

    p_head_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (hd_valid && !hd_pop) |=> (hd_valid && $stable(hd_addr) && $stable(hd_data) && $stable(hd_ts)));

    p_empty_pop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && !st_valid) |=> empty);
endmodule

bind pbuf_front pbuf_front_chk #(
    .DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TS_W(TS_W),
    .TID_W(TID_W), .PM_SEL_W(PM_SEL_W), .PM_SEL_VAL(PM_SEL_VAL)
) u_chk (.*);

// File: tb/pbuf_front_tb.sv
`timescale 1ns/1ps
module pbuf_front_tb;
    localparam int DEPTH = 4;
    localparam int AW = 8, DW = 8, TW = 4, IW = 2;

    logic clk = 0, rst_n = 0;
    logic st_valid = 0, ord_fence = 0, dur_fence = 0, dep_valid = 0, hd_pop = 0;
    logic [AW-1:0] st_addr = '0;
    logic [DW-1:0] st_data = '0;
    logic [IW-1:0] dep_tid = '0;
    logic [TW-1:0] dep_ts = '0;
    logic st_stall, hd_valid, hd_dep_valid, full, empty;
    logic [AW-1:0] hd_addr;
    logic [DW-1:0] hd_data;
    logic [TW-1:0] hd_ts, hd_dep_ts, local_ts;
    logic [IW-1:0] hd_dep_tid;

    always #5 clk = ~clk;

    pbuf_front #(.DEPTH(DEPTH), .ADDR_W(AW), .DATA_W(DW), .TS_W(TW),
                 .TID_W(IW), .PM_SEL_W(2), .PM_SEL_VAL(3)) u_dut (.*);

    typedef struct {
        logic [AW-1:0] a; logic [DW-1:0] d; logic [TW-1:0] t;
        logic dv; logic [IW-1:0] di; logic [TW-1:0] dt;
    } e_t;

    e_t q[$];
    logic [TW-1:0] mts = '0;
    logic pv = 0; logic [IW-1:0] pid = '0; logic [TW-1:0] pts = '0;
    int checks = 0, fails = 0;
    bit done = 0;

    task automatic chk(input string tag, input string what, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s got %0h expected %0h", tag, what, got, exp);
        end
    endtask

    task automatic chk_state(input string tag);
        chk(tag, "local_ts", 32'(local_ts), 32'(mts));
        chk(tag, "empty", 32'(empty), 32'(q.size() == 0));
        chk(tag, "full", 32'(full), 32'(q.size() == DEPTH));
        chk(tag, "hd_valid", 32'(hd_valid), 32'(q.size() != 0));
        if (q.size() != 0) begin
            chk(tag, "hd_addr", 32'(hd_addr), 32'(q[0].a));
            chk(tag, "hd_data", 32'(hd_data), 32'(q[0].d));
            chk(tag, "hd_ts", 32'(hd_ts), 32'(q[0].t));
            chk(tag, "hd_dep_valid", 32'(hd_dep_valid), 32'(q[0].dv));
            if (q[0].dv) begin
                chk(tag, "hd_dep_tid", 32'(hd_dep_tid), 32'(q[0].di));
                chk(tag, "hd_dep_ts", 32'(hd_dep_ts), 32'(q[0].dt));
            end
        end
    endtask

    // drive one cycle after a negedge, model it, check at the following negedge
    task automatic step(input string tag, input logic sv, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input logic of, input logic df, input logic dv, input logic [IW-1:0] di,
                        input logic [TW-1:0] dt, input logic pp);
        logic pm, fullm, push;
        e_t ne;
        st_valid = sv; st_addr = a; st_data = d; ord_fence = of; dur_fence = df;
        dep_valid = dv; dep_tid = di; dep_ts = dt; hd_pop = pp;
        #1;
        pm = (a[AW-1 -: 2] == 2'b11);
        fullm = (q.size() == DEPTH);
        push = sv && pm && !fullm;
        chk(tag, "st_stall", 32'(st_stall), 32'(sv && pm && fullm));
        if (pp && q.size() != 0) void'(q.pop_front());
        if (push) begin
            ne.a = a; ne.d = d; ne.t = mts; ne.dv = pv; ne.di = pid; ne.dt = pts;
            q.push_back(ne);
            pv = dv; pid = di; pts = dt;
        end else if (dv && (!pv || (di == pid && dt > pts))) begin
            pv = 1; pid = di; pts = dt;
        end
        mts = mts + TW'(of) + TW'(df);
        @(posedge clk);
        @(negedge clk);
        st_valid = 0; ord_fence = 0; dur_fence = 0; dep_valid = 0; hd_pop = 0;
        chk_state(tag);
    endtask

    task automatic st(input string tag, input logic [AW-1:0] a, input logic [DW-1:0] d);
        step(tag, 1, a, d, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic drain(input string tag);
        while (q.size() != 0) step(tag, 0, 0, 0, 0, 0, 0, 0, 0, 1);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [15:0] lf;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        chk_state("R1");

        // R2: every selector value other than 2'b11, then one persistent store
        for (int s = 0; s < 3; s++) st("R2", AW'(s << 6) | 8'h05, 8'h10 + DW'(s));
        st("R2", 8'hC5, 8'h33);
        drain("R2");

        // R3: single fences, both together, store in the same cycle as a fence
        step("R3", 0, 0, 0, 1, 0, 0, 0, 0, 0);
        step("R3", 0, 0, 0, 0, 1, 0, 0, 0, 0);
        step("R3", 0, 0, 0, 1, 1, 0, 0, 0, 0);
        step("R3", 1, 8'hC1, 8'h44, 1, 0, 0, 0, 0, 0);
        drain("R3");

        // R4 / R5: A=1, B=1, fence, A=2 -> three entries in order
        st("R4", 8'hCA, 8'h01);
        st("R4", 8'hCB, 8'h01);
        step("R5", 0, 0, 0, 1, 0, 0, 0, 0, 0);
        st("R5", 8'hCA, 8'h02);
        drain("R5");

        // R6: dependency lands on the next store only
        step("R6", 0, 0, 0, 0, 0, 1, 2'd1, 4'd9, 0);
        st("R6", 8'hD0, 8'h61);
        st("R6", 8'hD1, 8'h62);
        drain("R6");

        // R7: merge rule
        step("R7", 0, 0, 0, 0, 0, 1, 2'd1, 4'd5, 0);
        step("R7", 0, 0, 0, 0, 0, 1, 2'd1, 4'd3, 0);
        step("R7", 0, 0, 0, 0, 0, 1, 2'd1, 4'd7, 0);
        step("R7", 0, 0, 0, 0, 0, 1, 2'd2, 4'd9, 0);
        step("R7", 0, 0, 0, 0, 0, 1, 2'd1, 4'd7, 0);
        st("R7", 8'hE0, 8'h71);
        drain("R7");

        // R8: dependency in the same cycle as a store goes to the following store
        step("R8", 1, 8'hE1, 8'h81, 0, 0, 1, 2'd3, 4'd2, 0);
        st("R8", 8'hE2, 8'h82);
        drain("R8");

        // R9: fill, overflow attempt, pop plus store while full
        for (int i = 0; i < DEPTH; i++) st("R9", 8'hF0 + AW'(i), 8'h90 + DW'(i));
        st("R9", 8'hFF, 8'h99);
        step("R9", 1, 8'hFE, 8'h9A, 0, 0, 0, 0, 0, 1);
        st("R9", 8'hFD, 8'h9B);
        drain("R9");

        // R10: pops while empty
        step("R10", 0, 0, 0, 0, 0, 0, 0, 0, 1);
        step("R10", 0, 0, 0, 0, 0, 0, 0, 0, 1);

        // R11: wrap of the epoch counter
        for (int i = 0; i < 20; i++) step("R11", 0, 0, 0, 1, 0, 0, 0, 0, 0);
        st("R11", 8'hC7, 8'hB1);
        drain("R11");

        // pseudo-random sweep over all inputs
        lf = 16'hACE1;
        for (int i = 0; i < 1500; i++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            step("R4", lf[0], {lf[2:1], lf[8:3]}, lf[15:8], lf[9] & lf[3], lf[10] & lf[4],
                 lf[11] & lf[5], lf[13:12], lf[15:12], lf[14] | lf[6]);
        end
        drain("R10");

        done = 1;
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end
endmodule